// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit counter with a companion 16-bit reload/capture register. One counter serves four functions: capture of the count on an external trigger, auto-reload counting either upward or in both directions, baud-rate tick generation, and a 50% duty-cycle clock output. A byte-wide register port sets up the block and reads it back. Two external inputs feed it. The count input drives event counting. The trigger input gives a capture or reload strobe, and in up/down mode it sets the count direction.

The block runs on one clock, qualified by two strobes from the surrounding chip. The machine strobe pulses once every 12 clocks and the state strobe once every 2. Timer and event counting use the machine strobe. Baud and clock-out counting use the state strobe. The overflow and external flags leave the block as level outputs for an interrupt controller. A serial port downstream consumes the baud tick.

Top module: `mm_timer16`

## Requirements
- R1: Register map, byte wide. Address 0 is control: bit7 external flag, bit6 overflow flag, bit5 capture select, bit4 transmit-baud select, bit3 receive-baud select, bit2 trigger enable, bit1 counter select, bit0 run. Address 1 is mode: bit1 clock-out enable, bit0 down-count enable. Addresses 2 and 3 hold the count low and high bytes. Addresses 4 and 5 hold the reload low and high bytes. Reads return the stored values.
- R2: After reset, all registers read 0, including the down-count enable, and both flags, the clock-out pin and the baud tick are 0.
- R3: With run set and counter select clear, outside baud and clock-out modes, the count advances by one per machine strobe. State strobes do not advance it, and the count holds while run is clear.
- R4: With counter select set, the count input is sampled on each machine strobe. The count advances only when the previous sample was 1 and the current one is 0, so it advances at most once per two strobes.
- R5: In auto-reload mode (capture, down-count, baud and clock-out all off), a step taken at FFFFh loads the reload value and sets the overflow flag.
- R6: In auto-reload mode with trigger enable set, a trigger falling edge loads the count from the reload register and sets the external flag. The edge is a 1 sample followed by a 0 sample, both taken on machine strobes. With trigger enable clear, the edge has no effect.
- R7: In capture mode, a step at FFFFh wraps to 0 and sets the overflow flag. With trigger enable set, a trigger falling edge copies the count into the reload register and sets the external flag, leaving the count unchanged.
- R8: With down-count enable set, a trigger level of 1 counts up, reloading at FFFFh. A level of 0 counts down, and when the count equals the reload value the next step loads FFFFh. Both events set the overflow flag and toggle the external flag.
- R9: With either baud select set, the count advances per state strobe, and machine strobes alone do not advance it. A rollover reloads the count and pulses the baud tick for one clock. The overflow flag is unaffected.
- R10: In baud mode with trigger enable set, a trigger falling edge sets the external flag but does not reload the count.
- R11: With clock-out enable set and counter select clear, the count advances per state strobe and the clock-out pin toggles on each rollover. The overflow flag is unaffected, and clearing run stops the pin.
- R12: The overflow and external flags, once set, stay set until software writes 0 to them in the control register. The up/down toggling of R8 is the one exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mcyc_stb_i | input | 1 | Machine-cycle strobe (1 in 12 clocks) |
| state_stb_i | input | 1 | State-time strobe (1 in 2 clocks) |
| cnt_in_i | input | 1 | External event input |
| trig_i | input | 1 | External trigger / direction input |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| ovf_flag_o | output | 1 | Overflow flag |
| ext_flag_o | output | 1 | External flag |
| baud_tick_o | output | 1 | One-clock pulse per baud rollover |
| clk_out_o | output | 1 | Divided clock output |

## Verification
The bench targets the down-count underflow. It must compare against the reload value, not zero: a design that tests for zero walks straight past the reload value and never sets the overflow flag. It checks that the external flag toggles rather than sets in up/down mode, so a design that only sets it would leave the flag stuck at 1 after the second event. In baud mode it confirms that a trigger edge raises the flag without touching the count, which a design sharing the auto-reload path would reload. In counter mode it checks that a held-low input yields one step rather than one per strobe. It also checks that the state strobe is ignored in plain timer mode, where a design that mixes up the rate sources would count six times too fast.

// File: rtl/mm_tmr_pkg.sv
package mm_tmr_pkg;
  typedef enum logic [1:0] {
    MD_RELOAD  = 2'd0,
    MD_UPDOWN  = 2'd1,
    MD_CAPTURE = 2'd2,
    MD_FAST    = 2'd3
  } tmr_mode_e;

  // control byte bit positions
  localparam int unsigned CTL_RUN    = 0;
  localparam int unsigned CTL_CNTSEL = 1;
  localparam int unsigned CTL_EXTEN  = 2;
  localparam int unsigned CTL_RXB    = 3;
  localparam int unsigned CTL_TXB    = 4;
  localparam int unsigned CTL_CAP    = 5;
  localparam int unsigned CTL_OVF    = 6;
  localparam int unsigned CTL_EXT    = 7;

  // mode byte bit positions
  localparam int unsigned MDB_DOWN = 0;
  localparam int unsigned MDB_CLKO = 1;

  // register addresses; reload bytes follow the count bytes
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_MODE = 1;
  localparam int unsigned ADR_CNT  = 2;
endpackage

// File: rtl/mm_tmr_fall.sv
module mm_tmr_fall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic pin_i,
  output logic fall_o
);
  logic samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    samp_q <= 1'b0;
    else if (stb_i) samp_q <= pin_i;
  end

  // previous sample high, current sample low
  assign fall_o = stb_i & samp_q & ~pin_i;

  assert_count_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/mm_tmr_cfg.sv
module mm_tmr_cfg
  import mm_tmr_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   wr_addr_i,
  input  logic [5:0]      wr_data_i,
  output logic [5:0]      ctl_o,
  output logic [1:0]      md_o,
  output tmr_mode_e       mode_o,
  output logic            baud_o,
  output logic            clko_o
);
  logic [5:0] ctl_q;
  logic [1:0] md_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      md_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == AW'(ADR_CTRL)) ctl_q <= wr_data_i;
      if (wr_addr_i == AW'(ADR_MODE)) md_q  <= wr_data_i[1:0];
    end
  end

  always_comb begin
    baud_o = ctl_q[CTL_RXB] | ctl_q[CTL_TXB];
    clko_o = md_q[MDB_CLKO] & ~ctl_q[CTL_CNTSEL];
    if (baud_o || clko_o)        mode_o = MD_FAST;
    else if (ctl_q[CTL_CAP])     mode_o = MD_CAPTURE;
    else if (md_q[MDB_DOWN])     mode_o = MD_UPDOWN;
    else                         mode_o = MD_RELOAD;
  end

  assign ctl_o = ctl_q;
  assign md_o  = md_q;
endmodule

// File: rtl/mm_tmr_core.sv
module mm_tmr_core
  import mm_tmr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  tmr_mode_e     mode_i,
  input  logic          run_i,
  input  logic          cnt_sel_i,
  input  logic          ext_en_i,
  input  logic          baud_i,
  input  logic          clko_i,
  input  logic          mcyc_stb_i,
  input  logic          state_stb_i,
  input  logic          cnt_fall_i,
  input  logic          trig_fall_i,
  input  logic          trig_lvl_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] rld_o,
  output logic          ovf_o,
  output logic          ext_o,
  output logic          tick_o,
  output logic          clk_o
);
  localparam int unsigned NB       = CW / 8;
  localparam int unsigned RLD_BASE = ADR_CNT + NB;

  logic [CW-1:0] cnt_q, rld_q, cnt_d, rld_d;
  logic ovf_q, ext_q, tick_q, clk_q;
  logic ovf_d, ext_d, tick_d, clk_d;
  logic step, adv, top, at_rld, trig_act, ctl_wr, cnt_wr;
  logic is_ud, up_roll, dn_roll;

  always_comb begin
    if (!run_i)                  step = 1'b0;
    else if (cnt_sel_i)          step = cnt_fall_i;
    else if (mode_i == MD_FAST)  step = state_stb_i;
    else                         step = mcyc_stb_i;

    top      = &cnt_q;
    at_rld   = (cnt_q == rld_q);
    trig_act = ext_en_i & trig_fall_i;
    is_ud    = (mode_i == MD_UPDOWN);
    ctl_wr   = wr_en_i && (wr_addr_i == AW'(ADR_CTRL));

    cnt_d  = cnt_q;
    rld_d  = rld_q;
    cnt_wr = 1'b0;
    for (int unsigned b = 0; b < NB; b++) begin
      if (wr_en_i && wr_addr_i == AW'(ADR_CNT + b)) begin
        cnt_d[b*8 +: 8] = wr_data_i;
        cnt_wr          = 1'b1;
      end
      if (wr_en_i && wr_addr_i == AW'(RLD_BASE + b)) rld_d[b*8 +: 8] = wr_data_i;
    end

    // software count write takes the cycle
    adv     = step & ~cnt_wr;
    up_roll = adv & top & (~is_ud | trig_lvl_i);
    dn_roll = adv & is_ud & ~trig_lvl_i & at_rld;

    if (!cnt_wr) begin
      case (mode_i)
        MD_FAST: if (adv) cnt_d = top ? rld_q : cnt_q + 1'b1;
        MD_CAPTURE: if (adv) cnt_d = cnt_q + 1'b1;
        MD_UPDOWN: begin
          if (adv) begin
            if (trig_lvl_i) cnt_d = top ? rld_q : cnt_q + 1'b1;
            else            cnt_d = at_rld ? '1 : cnt_q - 1'b1;
          end
        end
        default: begin
          if (trig_act) cnt_d = rld_q;
          else if (adv) cnt_d = top ? rld_q : cnt_q + 1'b1;
        end
      endcase
    end

    if (trig_act && mode_i == MD_CAPTURE) rld_d = cnt_q;

    ovf_d  = ctl_wr ? wr_data_i[CTL_OVF] : ovf_q;
    ext_d  = ctl_wr ? wr_data_i[CTL_EXT] : ext_q;
    tick_d = 1'b0;
    clk_d  = clk_q;

    if (mode_i == MD_FAST) begin
      if (up_roll) begin
        tick_d = baud_i;
        if (clko_i) clk_d = ~clk_q;
      end
    end else if (up_roll || dn_roll) begin
      ovf_d = 1'b1;
    end

    if (is_ud && (up_roll || dn_roll)) ext_d = ~ext_d;
    if (trig_act && !is_ud)            ext_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      ovf_q  <= 1'b0;
      ext_q  <= 1'b0;
      tick_q <= 1'b0;
      clk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rld_q  <= rld_d;
      ovf_q  <= ovf_d;
      ext_q  <= ext_d;
      tick_q <= tick_d;
      clk_q  <= clk_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign ovf_o  = ovf_q;
  assign ext_o  = ext_q;
  assign tick_o = tick_q;
  assign clk_o  = clk_q;

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr && !(trig_act && mode_i == MD_RELOAD)) |=> $stable(cnt_q));

  assert_fast_no_ovf_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_FAST && !ctl_wr && !ovf_q) |=> !ovf_q);

  assert_clk_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clko_i |=> $stable(clk_q));

  assert_ovf_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ctl_wr) |=> ovf_q);

  assert_ext_sticky_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_q && !ctl_wr && !is_ud) |=> ext_q);
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
  import mm_tmr_pkg::*;
#(
  parameter  int unsigned CNT_W  = 16,
  localparam int unsigned NB     = CNT_W / 8,
  localparam int unsigned ADDR_W = $clog2(ADR_CNT + 2 * NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mcyc_stb_i,
  input  logic              state_stb_i,
  input  logic              cnt_in_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              ovf_flag_o,
  output logic              ext_flag_o,
  output logic              baud_tick_o,
  output logic              clk_out_o
);
  logic [5:0]       ctl;
  logic [1:0]       md;
  tmr_mode_e        mode;
  logic             baud, clko, cnt_fall, trig_fall;
  logic [CNT_W-1:0] cnt, rld;

  mm_tmr_fall u_cnt_fall (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(mcyc_stb_i),
    .pin_i (cnt_in_i), .fall_o(cnt_fall)
  );

  mm_tmr_fall u_trig_fall (
    .clk_i (clk_i), .rst_ni(rst_ni), .stb_i(mcyc_stb_i),
    .pin_i (trig_i), .fall_o(trig_fall)
  );

  mm_tmr_cfg #(.AW(ADDR_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i[5:0]),
    .ctl_o    (ctl),
    .md_o     (md),
    .mode_o   (mode),
    .baud_o   (baud),
    .clko_o   (clko)
  );

  mm_tmr_core #(.CW(CNT_W), .AW(ADDR_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_i     (mode),
    .run_i      (ctl[CTL_RUN]),
    .cnt_sel_i  (ctl[CTL_CNTSEL]),
    .ext_en_i   (ctl[CTL_EXTEN]),
    .baud_i     (baud),
    .clko_i     (clko),
    .mcyc_stb_i (mcyc_stb_i),
    .state_stb_i(state_stb_i),
    .cnt_fall_i (cnt_fall),
    .trig_fall_i(trig_fall),
    .trig_lvl_i (trig_i),
    .cnt_o      (cnt),
    .rld_o      (rld),
    .ovf_o      (ovf_flag_o),
    .ext_o      (ext_flag_o),
    .tick_o     (baud_tick_o),
    .clk_o      (clk_out_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADR_CTRL)) rd_data_o = {ext_flag_o, ovf_flag_o, ctl};
    if (rd_addr_i == ADDR_W'(ADR_MODE)) rd_data_o = {6'b0, md};
    for (int unsigned b = 0; b < NB; b++) begin
      if (rd_addr_i == ADDR_W'(ADR_CNT + b))      rd_data_o = cnt[b*8 +: 8];
      if (rd_addr_i == ADDR_W'(ADR_CNT + NB + b)) rd_data_o = rld[b*8 +: 8];
    end
  end
endmodule

// File: tb/mm_timer16_bench.sv
module mm_timer16_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mcyc_stb = 1'b0, state_stb = 1'b0, cnt_in = 1'b0, trig = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic       ovf_flag, ext_flag, baud_tick, clk_out;
  int         tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  mm_timer16 u_mm_timer16 (
    .clk_i(clk), .rst_ni(rst_n), .mcyc_stb_i(mcyc_stb), .state_stb_i(state_stb),
    .cnt_in_i(cnt_in), .trig_i(trig), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .ovf_flag_o(ovf_flag), .ext_flag_o(ext_flag), .baud_tick_o(baud_tick),
    .clk_out_o(clk_out)
  );

  // fields: reload, start count, machine strobes, expected count, expected overflow
  localparam logic [56:0] VECS [0:5] = '{
    {16'h1234, 16'hFFFE, 8'd1, 16'hFFFF, 1'b0},
    {16'h1234, 16'hFFFE, 8'd2, 16'h1234, 1'b1},
    {16'h1234, 16'hFFFE, 8'd3, 16'h1235, 1'b1},
    {16'h0000, 16'h0010, 8'd5, 16'h0015, 1'b0},
    {16'hFFFF, 16'hFFFF, 8'd1, 16'hFFFF, 1'b1},
    {16'h8000, 16'hFFFD, 8'd4, 16'h8001, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a, input logic [15:0] d);
    wr(a, d[7:0]); wr(a + 3'd1, d[15:8]);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1; d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi); d = {hi, lo};
  endtask

  task automatic pm();
    @(negedge clk); mcyc_stb = 1'b1;
    @(negedge clk); mcyc_stb = 1'b0;
  endtask

  task automatic ps();
    @(negedge clk); state_stb = 1'b1;
    @(negedge clk); state_stb = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(3'd0, b);  chk("R2 ctrl", b, 8'h00);
    rd(3'd1, b);  chk("R2 mode/down-enable", b, 8'h00);
    rd16(3'd2, w); chk("R2 count", w, 16'h0000);
    rd16(3'd4, w); chk("R2 reload", w, 16'h0000);
    chk("R2 pins", {ovf_flag, ext_flag, baud_tick, clk_out}, 4'b0000);

    // R1 register map readback
    wr(3'd0, 8'h24); rd(3'd0, b); chk("R1 ctrl", b, 8'h24);
    wr(3'd1, 8'h03); rd(3'd1, b); chk("R1 mode", b, 8'h03);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00);
    wr16(3'd2, 16'hA55A); rd16(3'd2, w); chk("R1 count", w, 16'hA55A);
    wr16(3'd4, 16'h1357); rd16(3'd4, w); chk("R1 reload", w, 16'h1357);

    // R5 auto-reload vectors
    for (int i = 0; i < 6; i++) begin
      logic [56:0] v;
      v = VECS[i];
      wr(3'd0, 8'h00);
      wr16(3'd4, v[56:41]);
      wr16(3'd2, v[40:25]);
      wr(3'd0, 8'h01);
      for (int k = 0; k < int'(v[24:17]); k++) pm();
      rd16(3'd2, w); chk("R5 count", w, v[16:1]);
      chk("R5 ovf flag", ovf_flag, v[0]);
    end

    // R3 timer rate and run gating
    wr(3'd0, 8'h00); wr16(3'd4, 16'h0000); wr16(3'd2, 16'h0100); wr(3'd0, 8'h01);
    repeat (3) ps();
    rd16(3'd2, w); chk("R3 state strobe ignored", w, 16'h0100);
    pm(); pm();
    rd16(3'd2, w); chk("R3 machine strobe count", w, 16'h0102);
    wr(3'd0, 8'h00); pm();
    rd16(3'd2, w); chk("R3 run clear holds", w, 16'h0102);

    // R4 event counting
    wr16(3'd2, 16'h0000); wr(3'd0, 8'h03);
    cnt_in = 1'b1; pm();
    rd16(3'd2, w); chk("R4 high sample no step", w, 16'h0000);
    cnt_in = 1'b0; pm();
    rd16(3'd2, w); chk("R4 fall steps", w, 16'h0001);
    pm();
    rd16(3'd2, w); chk("R4 held low no step", w, 16'h0001);
    cnt_in = 1'b1; pm(); cnt_in = 1'b0; pm();
    rd16(3'd2, w); chk("R4 second fall", w, 16'h0002);

    // R6 reload trigger
    wr(3'd0, 8'h00); wr16(3'd4, 16'h4321); wr16(3'd2, 16'h0005); wr(3'd0, 8'h04);
    trig = 1'b1; pm(); trig = 1'b0; pm();
    rd16(3'd2, w); chk("R6 trigger reload", w, 16'h4321);
    rd(3'd0, b);   chk("R6 ext flag set", b, 8'h84);
    wr(3'd0, 8'h00); wr16(3'd2, 16'h0005);
    trig = 1'b1; pm(); trig = 1'b0; pm();
    rd16(3'd2, w); chk("R6 disabled trigger ignored", w, 16'h0005);
    rd(3'd0, b);   chk("R6 disabled no flag", b, 8'h00);

    // R7 capture
    wr(3'd0, 8'h20); wr16(3'd4, 16'h0000); wr16(3'd2, 16'hFFFF); wr(3'd0, 8'h21);
    pm();
    rd16(3'd2, w); chk("R7 wrap to zero", w, 16'h0000);
    rd(3'd0, b);   chk("R7 ovf set", b, 8'h61);
    wr(3'd0, 8'h24); wr16(3'd2, 16'h2222);
    trig = 1'b1; pm(); trig = 1'b0; pm();
    rd16(3'd4, w); chk("R7 captured", w, 16'h2222);
    rd16(3'd2, w); chk("R7 count kept", w, 16'h2222);
    rd(3'd0, b);   chk("R7 ext flag", b, 8'hA4);

    // R8 up/down
    wr(3'd0, 8'h00); wr(3'd1, 8'h01); wr16(3'd4, 16'h0100); wr16(3'd2, 16'h0101);
    trig = 1'b0; wr(3'd0, 8'h01);
    pm();
    rd16(3'd2, w); chk("R8 count down", w, 16'h0100);
    rd(3'd0, b);   chk("R8 no flag yet", b, 8'h01);
    pm();
    rd16(3'd2, w); chk("R8 underflow loads FFFF", w, 16'hFFFF);
    rd(3'd0, b);   chk("R8 underflow flags", b, 8'hC1);
    trig = 1'b1; pm();
    rd16(3'd2, w); chk("R8 overflow reload", w, 16'h0100);
    rd(3'd0, b);   chk("R8 ext toggles back", b, 8'h41);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);

    // R9 baud
    wr16(3'd4, 16'hFFFE); wr16(3'd2, 16'hFFFE); wr(3'd0, 8'h09);
    pm();
    rd16(3'd2, w); chk("R9 machine strobe ignored", w, 16'hFFFE);
    ps();
    rd16(3'd2, w); chk("R9 state step", w, 16'hFFFF);
    chk("R9 no tick before rollover", baud_tick, 1'b0);
    ps();
    chk("R9 tick pulse", baud_tick, 1'b1);
    @(negedge clk);
    chk("R9 tick one clock", baud_tick, 1'b0);
    rd16(3'd2, w); chk("R9 rollover reload", w, 16'hFFFE);
    rd(3'd0, b);   chk("R9 ovf untouched", b, 8'h09);
    wr(3'd0, 8'h11); ps(); ps();
    chk("R9 transmit select tick", baud_tick, 1'b1);

    // R10 baud trigger
    wr(3'd0, 8'h0C); wr16(3'd2, 16'h3333);
    trig = 1'b1; pm(); trig = 1'b0; pm();
    rd16(3'd2, w); chk("R10 no reload", w, 16'h3333);
    rd(3'd0, b);   chk("R10 ext flag", b, 8'h8C);

    // R11 clock-out
    wr(3'd0, 8'h00); wr(3'd1, 8'h02); wr16(3'd4, 16'hFFFE); wr16(3'd2, 16'hFFFE);
    wr(3'd0, 8'h01);
    ps(); ps();
    chk("R11 pin toggles high", clk_out, 1'b1);
    chk("R11 no baud tick", baud_tick, 1'b0);
    rd(3'd0, b); chk("R11 ovf untouched", b, 8'h01);
    ps(); ps();
    chk("R11 pin toggles low", clk_out, 1'b0);
    wr(3'd0, 8'h00); ps(); ps(); ps();
    chk("R11 run clear stops pin", clk_out, 1'b0);
    wr(3'd1, 8'h00);

    // R12 sticky flags
    wr16(3'd4, 16'h0000); wr16(3'd2, 16'hFFFF); wr(3'd0, 8'h01);
    pm();
    repeat (20) @(negedge clk);
    pm(); pm();
    rd(3'd0, b); chk("R12 ovf held", b, 8'h41);
    wr(3'd0, 8'h01);
    rd(3'd0, b); chk("R12 software clear", b, 8'h01);

    summary();
    $finish;
  end
endmodule